// File: doc/BRIEF.md
# Memory Map Decoder with Keyboard Latch

This block sits on the 16-bit address bus of a small home-computer CPU. It sorts every access into one of three regions. Low memory is read/write RAM. A 4 KB window holds I/O registers. The top of the map is read-only ROM. In this block RAM and ROM are internal arrays. They alias onto their parameterised depth, so a test can reach every region without the full 64 KB of storage.

The I/O window holds a keyboard latch. The keyboard side delivers a 7-bit code together with a one-cycle valid pulse. The latch keeps that code and raises a "key waiting" flag in bit 7. Software polls the data address to see a key. It then reads a second address, which drops the flag as a side effect of the read and leaves the code in place.

Read data is registered. It appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `mmap_bus_top`

## Requirements
- R1: After reset, `cpu_rdata` is 0x00 and a read of 0xC000 returns 0x00.
- R2: Addresses 0x0000 to 0xBFFF are RAM. A read returns the last byte written to the same location. RAM aliases modulo 2^RAM_AW (1024 bytes by default), so 0xBFFF and 0x03FF are the same byte.
- R3: Addresses 0xD000 to 0xFFFF are ROM. The byte at address A is ((A mod 1024) * 7 + 0x3C) mod 256. Writes to ROM have no effect, either on the ROM or on RAM.
- R4: A read strobe high at a rising edge loads `cpu_rdata` at that edge. While no read strobe is seen, `cpu_rdata` holds its value.
- R5: A `key_valid` pulse loads `key_code` into bits 6:0 and sets bit 7. It overwrites any earlier key, whether that key was read or not.
- R6: A read of 0xC000 returns the latch, with bit 7 as the key-waiting flag. The read does not change the latch.
- R7: A read of 0xC010 clears bit 7 of the latch and keeps bits 6:0. The read returns the cleared value {0, bits 6:0}.
- R8: When `key_valid` and a read of 0xC010 fall in the same cycle, the new key wins: the latch becomes {1, new code}. The read returns {0, previous bits 6:0}.
- R9: A read of any I/O address (0xC000 to 0xCFFF) other than 0xC000 and 0xC010 returns 0x00. A write to any I/O address, including 0xC000 and 0xC010, changes neither the latch nor RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Bus address |
| cpu_rd | input | 1 | Read strobe, one access per cycle |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| key_code | input | 7 | Keyboard code |
| key_valid | input | 1 | One-cycle pulse: new key present |

## Verification
The bound checker watches the keyboard latch on every cycle. It checks that a key pulse loads it, that a strobe read clears only the flag, and that nothing else moves it. It also checks that read data holds between reads, that a read of 0xC000 or of an unused I/O address returns the right byte, and that ROM reads follow the fill pattern. RAM contents cannot be checked on every cycle, so only the bench scenarios show them. This covers RAM aliasing, ROM and I/O writes leaving RAM alone, overwriting of an unread key, the collision of a key pulse with a strobe read, and the reset state.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

   typedef enum logic [1:0] {
      RGN_RAM = 2'd0,
      RGN_IO  = 2'd1,
      RGN_ROM = 2'd2
   } region_e;

   // ROM fill pattern, indexed by the in-array offset
   function automatic logic [7:0] rom_fill(input logic [15:0] idx);
      logic [15:0] t;
      t = idx * 16'd7 + 16'h003C;
      return t[7:0];
   endfunction

endpackage

// File: rtl/mmap_region_dec.sv
module mmap_region_dec #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] IO_BASE  = 16'hC000,
   parameter logic [ADDR_W-1:0] ROM_BASE = 16'hD000
) (
   input  logic [ADDR_W-1:0] addr,
   output mmap_pkg::region_e region
);
   always_comb begin
      if (addr < IO_BASE)       region = mmap_pkg::RGN_RAM;
      else if (addr < ROM_BASE) region = mmap_pkg::RGN_IO;
      else                      region = mmap_pkg::RGN_ROM;
   end
endmodule

// File: rtl/mmap_store.sv
module mmap_store #(
   parameter int AW       = 10,
   parameter int DW       = 8,
   parameter bit WRITABLE = 1'b1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   generate
      if (WRITABLE) begin : g_rw
         logic [DW-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we) mem[addr] <= wdata;
         end
         assign rdata = mem[addr];
      end else begin : g_ro
         logic [DW-1:0] mem [DEPTH];
         logic          unused_wr;
         assign unused_wr = ^{we, wdata};
         initial begin
            for (int i = 0; i < DEPTH; i++)
               mem[i] = DW'(mmap_pkg::rom_fill(16'(i)));
         end
         assign rdata = mem[addr];
      end
   endgenerate
endmodule

// File: rtl/mmap_kbd_latch.sv
module mmap_kbd_latch #(
   parameter int CODE_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            key_valid,
   input  logic [CODE_W-1:0] key_code,
   input  logic            clr_rd,
   output logic [CODE_W:0] latch_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)         latch_q <= '0;
      else if (key_valid) latch_q <= {1'b1, key_code};
      else if (clr_rd)    latch_q[CODE_W] <= 1'b0;
   end
endmodule

// File: rtl/mmap_bus_top.sv
module mmap_bus_top #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int RAM_AW = 10,
   parameter int ROM_AW = 10,
   parameter logic [15:0] IO_BASE  = 16'hC000,
   parameter logic [15:0] ROM_BASE = 16'hD000,
   parameter logic [15:0] KBD_ADDR = 16'hC000,
   parameter logic [15:0] CLR_ADDR = 16'hC010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [DATA_W-2:0] key_code,
   input  logic              key_valid
);
   localparam int CODE_W = DATA_W - 1;

   generate
      if (ADDR_W != 16) begin : g_bad_aw
         $error("mmap_bus_top: ADDR_W must be 16");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("mmap_bus_top: DATA_W must be 8");
      end
      if (ROM_BASE <= IO_BASE) begin : g_bad_order
         $error("mmap_bus_top: ROM_BASE must lie above IO_BASE");
      end
      if (KBD_ADDR < IO_BASE || KBD_ADDR >= ROM_BASE ||
          CLR_ADDR < IO_BASE || CLR_ADDR >= ROM_BASE ||
          KBD_ADDR == CLR_ADDR) begin : g_bad_kbd
         $error("mmap_bus_top: keyboard registers must be distinct I/O addresses");
      end
      if (RAM_AW > ADDR_W || ROM_AW > ADDR_W) begin : g_bad_depth
         $error("mmap_bus_top: array depth exceeds address space");
      end
   endgenerate

   mmap_pkg::region_e region;
   logic [DATA_W-1:0] ram_rd, rom_rd;
   logic [DATA_W-1:0] kbd_q;
   logic              ram_we, hit_kbd, hit_clr, clr_rd;
   logic [DATA_W-1:0] rd_mux;

   mmap_region_dec #(
      .ADDR_W  (ADDR_W),
      .IO_BASE (IO_BASE),
      .ROM_BASE(ROM_BASE)
   ) u_dec (
      .addr  (cpu_addr),
      .region(region)
   );

   assign ram_we  = cpu_wr && (region == mmap_pkg::RGN_RAM);
   assign hit_kbd = (cpu_addr == KBD_ADDR);
   assign hit_clr = (cpu_addr == CLR_ADDR);
   assign clr_rd  = cpu_rd && hit_clr;

   mmap_store #(.AW(RAM_AW), .DW(DATA_W), .WRITABLE(1'b1)) u_ram (
      .clk  (clk),
      .we   (ram_we),
      .addr (cpu_addr[RAM_AW-1:0]),
      .wdata(cpu_wdata),
      .rdata(ram_rd)
   );

   mmap_store #(.AW(ROM_AW), .DW(DATA_W), .WRITABLE(1'b0)) u_rom (
      .clk  (clk),
      .we   (1'b0),
      .addr (cpu_addr[ROM_AW-1:0]),
      .wdata(cpu_wdata),
      .rdata(rom_rd)
   );

   mmap_kbd_latch #(.CODE_W(CODE_W)) u_kbd (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_valid(key_valid),
      .key_code (key_code),
      .clr_rd   (clr_rd),
      .latch_q  (kbd_q)
   );

   always_comb begin
      unique case (region)
         mmap_pkg::RGN_RAM: rd_mux = ram_rd;
         mmap_pkg::RGN_ROM: rd_mux = rom_rd;
         default: begin
            if (hit_kbd)      rd_mux = kbd_q;
            else if (hit_clr) rd_mux = {1'b0, kbd_q[CODE_W-1:0]};
            else              rd_mux = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cpu_rdata <= '0;
      else if (cpu_rd) cpu_rdata <= rd_mux;
   end
endmodule

// File: rtl/mmap_bus_checker.sv
module mmap_bus_checker #(
   parameter int ROM_AW = 10,
   parameter logic [15:0] IO_BASE  = 16'hC000,
   parameter logic [15:0] ROM_BASE = 16'hD000,
   parameter logic [15:0] KBD_ADDR = 16'hC000,
   parameter logic [15:0] CLR_ADDR = 16'hC010
) (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] cpu_addr,
   input logic        cpu_rd,
   input logic [7:0]  cpu_rdata,
   input logic [6:0]  key_code,
   input logic        key_valid,
   input logic [7:0]  kbd_q
);
   localparam logic [15:0] ROM_MASK = 16'((32'd1 << ROM_AW) - 1);

   logic io_rd, strobe_rd, undef_io_rd, rom_rd;
   assign io_rd       = cpu_rd && cpu_addr >= IO_BASE && cpu_addr < ROM_BASE;
   assign strobe_rd   = cpu_rd && cpu_addr == CLR_ADDR;
   assign undef_io_rd = io_rd && cpu_addr != KBD_ADDR && cpu_addr != CLR_ADDR;
   assign rom_rd      = cpu_rd && cpu_addr >= ROM_BASE;

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> $stable(cpu_rdata)) else $error("rdata moved without read"); // R4

   AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> kbd_q == {1'b1, $past(key_code)}) else $error("key not loaded"); // R5

   AST_STROBE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_rd && !key_valid) |=> (!kbd_q[7] && kbd_q[6:0] == $past(kbd_q[6:0])))
      else $error("strobe clear wrong"); // R7

   AST_STROBE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_rd |=> cpu_rdata == {1'b0, $past(kbd_q[6:0])}) else $error("strobe data"); // R8

   AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!key_valid && !strobe_rd) |=> $stable(kbd_q)) else $error("latch moved"); // R9

   AST_KBD_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_addr == KBD_ADDR) |=> cpu_rdata == $past(kbd_q)) else $error("kbd read"); // R6

   AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      undef_io_rd |=> cpu_rdata == 8'h00) else $error("undefined I/O not zero"); // R9

   AST_ROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd |=> cpu_rdata == mmap_pkg::rom_fill($past(cpu_addr) & ROM_MASK))
      else $error("rom data"); // R3
endmodule

bind mmap_bus_top mmap_bus_checker #(
   .ROM_AW  (ROM_AW),
   .IO_BASE (IO_BASE),
   .ROM_BASE(ROM_BASE),
   .KBD_ADDR(KBD_ADDR),
   .CLR_ADDR(CLR_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_addr (cpu_addr),
   .cpu_rd   (cpu_rd),
   .cpu_rdata(cpu_rdata),
   .key_code (key_code),
   .key_valid(key_valid),
   .kbd_q    (kbd_q)
);

// File: tb/tb_mmap_bus_top.sv
module tb_mmap_bus_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic [6:0]  key_code = '0;
   logic        key_valid = 1'b0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   mmap_bus_top dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .key_code(key_code), .key_valid(key_valid)
   );

   // op: 0 write, 1 read-and-check, 2 key pulse | addr | data | expected | req
   localparam int NV = 28;
   localparam logic [37:0] VEC [NV] = '{
      {2'd0, 16'h0000, 8'h11, 8'h00, 4'd2},
      {2'd0, 16'h03FF, 8'h22, 8'h00, 4'd2},
      {2'd1, 16'h0000, 8'h00, 8'h11, 4'd2},   // R2 RAM readback
      {2'd1, 16'h03FF, 8'h00, 8'h22, 4'd2},
      {2'd0, 16'hBFFF, 8'h5A, 8'h00, 4'd2},
      {2'd1, 16'h03FF, 8'h00, 8'h5A, 4'd2},   // R2 aliasing
      {2'd1, 16'hD000, 8'h00, 8'h3C, 4'd3},   // R3 ROM pattern
      {2'd1, 16'hFFFF, 8'h00, 8'h35, 4'd3},
      {2'd0, 16'hD001, 8'h77, 8'h00, 4'd3},
      {2'd1, 16'hD001, 8'h00, 8'h43, 4'd3},   // R3 write ignored
      {2'd0, 16'hE000, 8'hAB, 8'h00, 4'd3},
      {2'd1, 16'h0000, 8'h00, 8'h11, 4'd3},   // R3 no RAM alias
      {2'd1, 16'hC000, 8'h00, 8'h00, 4'd1},   // R1 latch empty
      {2'd2, 16'h0000, 8'h41, 8'h00, 4'd5},
      {2'd1, 16'hC000, 8'h00, 8'hC1, 4'd5},   // R5 load
      {2'd1, 16'hC000, 8'h00, 8'hC1, 4'd6},   // R6 no side effect
      {2'd1, 16'hC010, 8'h00, 8'h41, 4'd7},   // R7 strobe
      {2'd1, 16'hC000, 8'h00, 8'h41, 4'd7},
      {2'd2, 16'h0000, 8'h7F, 8'h00, 4'd5},
      {2'd2, 16'h0000, 8'h12, 8'h00, 4'd5},
      {2'd1, 16'hC000, 8'h00, 8'h92, 4'd5},   // R5 overwrite
      {2'd0, 16'hC000, 8'hFF, 8'h00, 4'd9},
      {2'd1, 16'hC000, 8'h00, 8'h92, 4'd9},   // R9 write C000
      {2'd0, 16'hC010, 8'h00, 8'h00, 4'd9},
      {2'd1, 16'hC000, 8'h00, 8'h92, 4'd9},   // R9 write C010
      {2'd1, 16'hC055, 8'h00, 8'h00, 4'd9},   // R9 undefined I/O
      {2'd0, 16'hC000, 8'h99, 8'h00, 4'd9},
      {2'd1, 16'h0000, 8'h00, 8'h11, 4'd9}    // R9 no RAM write
   };

   task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [15:0] a, input logic [7:0] exp, input string req);
      cpu_addr = a; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      chk(cpu_rdata, exp, req);
   endtask

   task automatic do_key(input logic [6:0] k);
      key_code = k; key_valid = 1'b1;
      @(negedge clk);
      key_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(cpu_rdata, 8'h00, "R1 reset rdata");

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [15:0] a;
         logic [7:0]  d, e;
         logic [3:0]  r;
         {op, a, d, e, r} = VEC[i];
         case (op)
            2'd0: do_wr(a, d);
            2'd1: do_rd(a, e, $sformatf("R%0d vector %0d", r, i));
            default: do_key(d[6:0]);
         endcase
      end

      // R4: latency and hold
      cpu_addr = 16'hD000; cpu_rd = 1'b1;
      #1 chk(cpu_rdata, 8'h11, "R4 before edge");
      @(negedge clk);
      cpu_rd = 1'b0;
      chk(cpu_rdata, 8'h3C, "R4 after edge");
      cpu_addr = 16'h0000;
      repeat (3) @(negedge clk);
      chk(cpu_rdata, 8'h3C, "R4 hold");

      // R8: key pulse collides with strobe read (latch holds 0x92)
      cpu_addr = 16'hC010; cpu_rd = 1'b1; key_code = 7'h05; key_valid = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0; key_valid = 1'b0;
      chk(cpu_rdata, 8'h12, "R8 collision read data");
      do_rd(16'hC000, 8'h85, "R8 new key wins");
      do_rd(16'hCFFF, 8'h00, "R9 last I/O address");

      // R1: reset in mid-run
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(cpu_rdata, 8'h00, "R1 reset clears rdata");
      do_rd(16'hC000, 8'h00, "R1 reset clears latch");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule